// File: doc/BRIEF.md
# Chain-Following Frame Fetch DMA

This block moves display data from memory toward a panel controller by walking a linked list of four-word descriptors held in memory. Software hands it the address of the first descriptor through a start pulse. The block reads the descriptor as one four-word burst. It then streams the source region the descriptor names, in read bursts, either into the pixel output FIFO or, when the descriptor is flagged as palette data, into a separate palette write port. After that it jumps to the next descriptor the list points to. Because the list may point back at itself, a single self-linked frame descriptor refreshes the screen forever. A palette descriptor and a frame descriptor that point at each other give the alternating load used by indexed-colour modes.

Each descriptor, at byte offsets +0, +4, +8 and +12, carries the next descriptor address, the source data address, a frame ID and a command word. The command's low 24 bits are the length in 32-bit words, and bit 28 routes the data to the palette. Memory is reached through a request/acknowledge port with one burst outstanding. After acknowledging a request, memory returns exactly the requested number of words, in address order, on cycles marked by a valid strobe. Gaps between words are allowed. A completion strobe reports the frame ID of every finished descriptor. On the FIFO read side, a small guard feeds pixels to the panel and covers underruns: it repeats the last pixel and records a sticky flag.

Top module: `chain_fetch_dma`

## Requirements
- R1: A start pulse while idle makes the block issue one read burst of length 4 at the given start address. The words returned are taken as next pointer (+0), source address (+4), frame ID (+8) and command (+12). A start pulse while busy is ignored.
- R2: The transfer length is command bits 23:0, in 32-bit words. The data words are read from consecutive byte addresses starting at the source address, in steps of 4, and each word is written out exactly once, in order.
- R3: When command bit 28 is 1, every data word goes to the palette port and none to the FIFO. When it is 0, every word goes to the FIFO and none to the palette port.
- R4: burst_sel selects the data burst size: 0 gives 4 words, 1 gives 8, and 2 or 3 give 16. Every data burst of a descriptor has that size except the last, which carries only the words that remain.
- R5: A FIFO-bound data burst is requested only when fifo_free is at least that burst's length. Palette bursts do not wait for FIFO space.
- R6: When a descriptor completes, done_stb is high for one cycle with done_fid equal to that descriptor's frame ID. A zero-length descriptor produces its strobe with no data reads.
- R7: After a descriptor completes, the next descriptor is fetched at that descriptor's next pointer, so self-loops and two-descriptor alternation repeat.
- R8: A stop_req pulse lets the descriptor in progress finish with its strobe. The block then goes idle (busy low) without fetching further.
- R9: mem_req stays high with mem_addr and mem_len unchanged until mem_ack, and only one burst is outstanding at a time.
- R10: A pixel read (pix_rd) while fifo_empty is low raises fifo_rd in the same cycle and loads fifo_rdata onto pix_out on the next clock.
- R11: A pixel read while the FIFO is empty keeps fifo_rd low and sets underrun_flag, which stays set until the next start pulse. pix_out repeats its previous value when underrun_en is 1 and becomes 0 when it is 0.
- R12: While reset is asserted, mem_req, busy, fifo_wr, pal_wr, done_stb and underrun_flag are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin walking the list at start_addr; also clears underrun_flag |
| start_addr | input | AW | Byte address of the first descriptor |
| stop_req | input | 1 | Finish the current descriptor, then go idle |
| burst_sel | input | 2 | Data burst size select |
| underrun_en | input | 1 | Repeat the last pixel on an empty-FIFO read |
| busy | output | 1 | List walk in progress |
| mem_req | output | 1 | Read burst request |
| mem_addr | output | AW | Burst start byte address |
| mem_len | output | 5 | Burst length in words |
| mem_ack | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read word valid |
| mem_rdata | input | DW | Read word |
| fifo_free | input | FREE_W | Free word slots in the pixel FIFO |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_wdata | output | DW | FIFO write word |
| pal_wr | output | 1 | Palette write strobe |
| pal_wdata | output | DW | Palette write word |
| done_stb | output | 1 | Descriptor complete |
| done_fid | output | DW | Frame ID of the completed descriptor |
| pix_rd | input | 1 | Panel side requests a pixel word |
| fifo_empty | input | 1 | Pixel FIFO empty |
| fifo_rdata | input | DW | Pixel FIFO head word |
| fifo_rd | output | 1 | Pop the pixel FIFO |
| pix_out | output | DW | Pixel word to the panel |
| underrun_flag | output | 1 | Sticky empty-read indicator |

## Verification
Single self-linked descriptors are run with lengths of one word, exactly one burst, a multiple of the burst size and a remainder past it. These are spread over all four burst_sel codes, with and without gaps in the read responses. Together they separate a wrong burst size, a missing shortened tail burst and a slip in address stepping. Palette and frame descriptors carrying the same data show whether routing follows bit 28. A two-descriptor alternating chain is stopped part-way and hit with a stray start pulse, which shows whether next pointers, the stop point and busy-time start rejection are right. A FIFO with too little space, a zero-length descriptor, and empty-FIFO reads with repetition on and off cover the remaining corners.

// File: rtl/cff_pkg.sv
package cff_pkg;
  localparam int DESC_WORDS = 4;
  localparam int PAL_BIT    = 28;
  localparam int MAX_BURST  = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DREQ,
    ST_DRCV,
    ST_XREQ,
    ST_XRCV,
    ST_FIN
  } fetch_st_e;

  function automatic int burst_words(input logic [1:0] sel);
    case (sel)
      2'd0:    return 4;
      2'd1:    return 8;
      default: return MAX_BURST;
    endcase
  endfunction
endpackage

// File: rtl/cff_burst_plan.sv
module cff_burst_plan
  import cff_pkg::*;
#(
  parameter int LEN_W  = 24,
  parameter int BL_W   = 5,
  parameter int FREE_W = 6
) (
  input  logic [1:0]        burst_sel,
  input  logic [LEN_W-1:0]  remain,
  input  logic              to_palette,
  input  logic [FREE_W-1:0] fifo_free,
  output logic [BL_W-1:0]   blen,
  output logic              room_ok
);
  logic [BL_W-1:0] bsize;

  always_comb begin
    bsize = BL_W'(burst_words(burst_sel));
    if (remain < LEN_W'(bsize)) begin
      blen = remain[BL_W-1:0];
    end else begin
      blen = bsize;
    end
    room_ok = to_palette || (fifo_free >= FREE_W'(blen));
  end
endmodule

// File: rtl/cff_chain_ctrl.sv
module cff_chain_ctrl
  import cff_pkg::*;
#(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int LEN_W  = 24,
  parameter int BL_W   = 5,
  parameter int FREE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [AW-1:0]     start_addr,
  input  logic              stop_req,
  input  logic [1:0]        burst_sel,
  input  logic [FREE_W-1:0] fifo_free,
  output logic              mem_req,
  output logic [AW-1:0]     mem_addr,
  output logic [BL_W-1:0]   mem_len,
  input  logic              mem_ack,
  input  logic              mem_rvalid,
  input  logic [DW-1:0]     mem_rdata,
  output logic              fifo_wr,
  output logic              pal_wr,
  output logic [DW-1:0]     wdata,
  output logic              done_stb,
  output logic [DW-1:0]     done_fid,
  output logic              busy
);
  fetch_st_e         st_q, st_n;
  logic [AW-1:0]     da_q, da_n, sa_q, sa_n, addr_q, addr_n;
  logic [DW-1:0]     fid_q, fid_n, wd_q, wd_n, dfid_q, dfid_n;
  logic [LEN_W-1:0]  rem_q, rem_n;
  logic [BL_W-1:0]   cnt_q, cnt_n, len_q, len_n;
  logic              pal_q, pal_n, req_q, req_n, stop_q, stop_n;
  logic              fw_q, fw_n, pw_q, pw_n, dn_q, dn_n;
  logic [BL_W-1:0]   plan_len;
  logic              plan_room;
  logic              ld_desc, ld_data;

  cff_burst_plan #(.LEN_W(LEN_W), .BL_W(BL_W), .FREE_W(FREE_W)) u_plan (
    .burst_sel (burst_sel),
    .remain    (rem_q),
    .to_palette(pal_q),
    .fifo_free (fifo_free),
    .blen      (plan_len),
    .room_ok   (plan_room)
  );

  // next-state logic
  always_comb begin
    st_n   = st_q;
    da_n   = da_q;
    sa_n   = sa_q;
    addr_n = addr_q;
    fid_n  = fid_q;
    wd_n   = wd_q;
    dfid_n = dfid_q;
    rem_n  = rem_q;
    cnt_n  = cnt_q;
    len_n  = len_q;
    pal_n  = pal_q;
    req_n  = req_q;
    stop_n = stop_q;
    fw_n   = 1'b0;
    pw_n   = 1'b0;
    dn_n   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          da_n   = start_addr;
          stop_n = 1'b0;
          st_n   = ST_DREQ;
        end
      end
      ST_DREQ: begin
        if (!req_q) begin
          req_n  = 1'b1;
          addr_n = da_q;
          len_n  = BL_W'(DESC_WORDS);
        end else if (mem_ack) begin
          req_n = 1'b0;
          cnt_n = '0;
          st_n  = ST_DRCV;
        end
      end
      ST_DRCV: begin
        if (mem_rvalid) begin
          cnt_n = cnt_q + BL_W'(1);
          case (cnt_q[1:0])
            2'd0: da_n  = mem_rdata[AW-1:0];
            2'd1: sa_n  = mem_rdata[AW-1:0];
            2'd2: fid_n = mem_rdata;
            default: begin
              pal_n = mem_rdata[PAL_BIT];
              rem_n = mem_rdata[LEN_W-1:0];
              st_n  = (mem_rdata[LEN_W-1:0] == '0) ? ST_FIN : ST_XREQ;
            end
          endcase
        end
      end
      ST_XREQ: begin
        if (!req_q) begin
          if (plan_room) begin
            req_n  = 1'b1;
            addr_n = sa_q;
            len_n  = plan_len;
          end
        end else if (mem_ack) begin
          req_n = 1'b0;
          cnt_n = len_q;
          st_n  = ST_XRCV;
        end
      end
      ST_XRCV: begin
        if (mem_rvalid) begin
          wd_n  = mem_rdata;
          pw_n  = pal_q;
          fw_n  = !pal_q;
          sa_n  = sa_q + AW'(4);
          rem_n = rem_q - LEN_W'(1);
          cnt_n = cnt_q - BL_W'(1);
          if (cnt_q == BL_W'(1)) begin
            st_n = (rem_q == LEN_W'(1)) ? ST_FIN : ST_XREQ;
          end
        end
      end
      ST_FIN: begin
        dn_n   = 1'b1;
        dfid_n = fid_q;
        st_n   = (stop_q || stop_req) ? ST_IDLE : ST_DREQ;
      end
      default: st_n = ST_IDLE;
    endcase
    if (stop_req) begin
      stop_n = 1'b1;
    end
  end

  assign ld_desc = (st_q == ST_DRCV) || (st_q == ST_IDLE) || (st_q == ST_FIN);
  assign ld_data = (st_q == ST_XRCV) || (st_q == ST_DRCV);

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      req_q  <= 1'b0;
      stop_q <= 1'b0;
      fw_q   <= 1'b0;
      pw_q   <= 1'b0;
      dn_q   <= 1'b0;
      cnt_q  <= '0;
      addr_q <= '0;
      len_q  <= '0;
    end else begin
      st_q   <= st_n;
      req_q  <= req_n;
      stop_q <= stop_n;
      fw_q   <= fw_n;
      pw_q   <= pw_n;
      dn_q   <= dn_n;
      cnt_q  <= cnt_n;
      addr_q <= addr_n;
      len_q  <= len_n;
    end
  end

  // descriptor and data registers with explicit load enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      da_q   <= '0;
      sa_q   <= '0;
      fid_q  <= '0;
      pal_q  <= 1'b0;
      rem_q  <= '0;
      wd_q   <= '0;
      dfid_q <= '0;
    end else begin
      if (ld_desc) begin
        da_q   <= da_n;
        fid_q  <= fid_n;
        dfid_q <= dfid_n;
      end
      if (ld_data) begin
        sa_q  <= sa_n;
        pal_q <= pal_n;
        rem_q <= rem_n;
        wd_q  <= wd_n;
      end
    end
  end

  assign mem_req  = req_q;
  assign mem_addr = addr_q;
  assign mem_len  = len_q;
  assign fifo_wr  = fw_q;
  assign pal_wr   = pw_q;
  assign wdata    = wd_q;
  assign done_stb = dn_q;
  assign done_fid = dfid_q;
  assign busy     = (st_q != ST_IDLE);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_len)); // R9
  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_len != '0) && (mem_len <= BL_W'(MAX_BURST))); // R4
  AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_wr && pal_wr)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_stb |=> !done_stb); // R6
  AST_FIFO_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) && (st_q == ST_XREQ) && !pal_q |-> $past(fifo_free) >= FREE_W'(mem_len)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !fifo_wr && !pal_wr); // R8
endmodule

// File: rtl/cff_underrun_guard.sv
module cff_underrun_guard #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          hold_en,
  input  logic          pix_rd,
  input  logic          fifo_empty,
  input  logic [DW-1:0] fifo_rdata,
  output logic          fifo_rd,
  output logic [DW-1:0] pix_out,
  output logic          underrun_flag
);
  logic [DW-1:0] pix_q, pix_n;
  logic          flag_q, flag_n;
  logic          pix_en;

  always_comb begin
    pix_n  = pix_q;
    flag_n = flag_q;
    if (clr) begin
      flag_n = 1'b0;
    end
    if (pix_rd) begin
      if (!fifo_empty) begin
        pix_n = fifo_rdata;
      end else begin
        flag_n = 1'b1;
        if (!hold_en) begin
          pix_n = '0;
        end
      end
    end
  end

  assign pix_en = pix_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (pix_en) begin
        pix_q <= pix_n;
      end
      flag_q <= flag_n;
    end
  end

  assign fifo_rd       = pix_rd && !fifo_empty;
  assign pix_out       = pix_q;
  assign underrun_flag = flag_q;

  AST_POP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    pix_rd && !fifo_empty |=> pix_out == $past(fifo_rdata)); // R10
  AST_HOLD_PIX: assert property (@(posedge clk) disable iff (!rst_n)
    pix_rd && fifo_empty && hold_en |=> $stable(pix_out)); // R11
  AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    pix_rd && fifo_empty && !hold_en |=> pix_out == '0); // R11
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_flag && !clr |=> underrun_flag); // R11
endmodule

// File: rtl/chain_fetch_dma.sv
module chain_fetch_dma
  import cff_pkg::*;
#(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int LEN_W  = 24,
  parameter int FREE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [AW-1:0]     start_addr,
  input  logic              stop_req,
  input  logic [1:0]        burst_sel,
  input  logic              underrun_en,
  output logic              busy,
  output logic              mem_req,
  output logic [AW-1:0]     mem_addr,
  output logic [4:0]        mem_len,
  input  logic              mem_ack,
  input  logic              mem_rvalid,
  input  logic [DW-1:0]     mem_rdata,
  input  logic [FREE_W-1:0] fifo_free,
  output logic              fifo_wr,
  output logic [DW-1:0]     fifo_wdata,
  output logic              pal_wr,
  output logic [DW-1:0]     pal_wdata,
  output logic              done_stb,
  output logic [DW-1:0]     done_fid,
  input  logic              pix_rd,
  input  logic              fifo_empty,
  input  logic [DW-1:0]     fifo_rdata,
  output logic              fifo_rd,
  output logic [DW-1:0]     pix_out,
  output logic              underrun_flag
);
  localparam int BL_W     = $clog2(MAX_BURST) + 1;
  localparam int RST_SYNC = 2;

  logic [RST_SYNC-1:0] rst_pipe;
  logic                rst_int_n;
  logic [DW-1:0]       wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[RST_SYNC-2:0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe[RST_SYNC-1];

  cff_chain_ctrl #(
    .AW(AW), .DW(DW), .LEN_W(LEN_W), .BL_W(BL_W), .FREE_W(FREE_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start     (start),
    .start_addr(start_addr),
    .stop_req  (stop_req),
    .burst_sel (burst_sel),
    .fifo_free (fifo_free),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_len   (mem_len),
    .mem_ack   (mem_ack),
    .mem_rvalid(mem_rvalid),
    .mem_rdata (mem_rdata),
    .fifo_wr   (fifo_wr),
    .pal_wr    (pal_wr),
    .wdata     (wdata),
    .done_stb  (done_stb),
    .done_fid  (done_fid),
    .busy      (busy)
  );

  assign fifo_wdata = wdata;
  assign pal_wdata  = wdata;

  cff_underrun_guard #(.DW(DW)) u_guard (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .clr          (start),
    .hold_en      (underrun_en),
    .pix_rd       (pix_rd),
    .fifo_empty   (fifo_empty),
    .fifo_rdata   (fifo_rdata),
    .fifo_rd      (fifo_rd),
    .pix_out      (pix_out),
    .underrun_flag(underrun_flag)
  );
endmodule

// File: tb/chain_fetch_dma_test.sv
module chain_fetch_dma_test;
  localparam int AW = 32, DW = 32, FREE_W = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, start, stop_req, underrun_en, busy;
  logic [AW-1:0] start_addr, mem_addr;
  logic [1:0] burst_sel;
  logic mem_req, mem_ack, mem_rvalid;
  logic [4:0] mem_len;
  logic [DW-1:0] mem_rdata, fifo_wdata, pal_wdata, done_fid, fifo_rdata, pix_out;
  logic [FREE_W-1:0] fifo_free;
  logic fifo_wr, pal_wr, done_stb, pix_rd, fifo_empty, fifo_rd, underrun_flag;

  chain_fetch_dma uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr), .stop_req(stop_req),
    .burst_sel(burst_sel), .underrun_en(underrun_en), .busy(busy),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_len(mem_len), .mem_ack(mem_ack),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .fifo_free(fifo_free),
    .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata), .pal_wr(pal_wr), .pal_wdata(pal_wdata),
    .done_stb(done_stb), .done_fid(done_fid), .pix_rd(pix_rd), .fifo_empty(fifo_empty),
    .fifo_rdata(fifo_rdata), .fifo_rd(fifo_rd), .pix_out(pix_out), .underrun_flag(underrun_flag)
  );

  logic [DW-1:0] mem_w [0:255];
  logic gap_mode;
  int req_cnt, fifo_cnt, pal_cnt, done_cnt;
  logic [AW-1:0] req_a [0:63];
  int req_l [0:63];
  logic [DW-1:0] fifo_log [0:127];
  logic [DW-1:0] pal_log [0:127];
  logic [DW-1:0] done_log [0:15];
  logic [AW-1:0] rsp_a;
  int rsp_l;
  int n_vec, n_bad;

  // {2'b0, sel[1:0], pal, gap, 2'b0, len[7:0], fid[7:0]}
  localparam logic [23:0] VEC [0:6] = '{
    24'h000111,  // 4-word bursts, 1 word
    24'h040412,  // 4-word bursts, exactly one burst, gaps
    24'h101113,  // 8-word bursts, 17 words
    24'h202814,  // 16-word bursts, 40 words
    24'h281415,  // 16-word bursts, palette, 20 words
    24'h302116,  // code 3 -> 16-word bursts, 33 words
    24'h1C0817   // 8-word bursts, palette, gaps, 8 words
  };

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic clear_logs();
    req_cnt = 0; fifo_cnt = 0; pal_cnt = 0; done_cnt = 0;
  endtask

  task automatic wait_idle();
    int t = 0;
    @(negedge clk);
    while (busy && t < 20000) begin
      @(negedge clk);
      t++;
    end
  endtask

  task automatic kick(input logic [AW-1:0] a, input bit stop);
    @(negedge clk);
    start = 1'b1; start_addr = a; stop_req = stop;
    @(negedge clk);
    start = 1'b0; stop_req = 1'b0;
  endtask

  task automatic put_desc(input int idx, input logic [31:0] nxt, input logic [31:0] src,
                          input logic [31:0] fid, input bit pal, input int len);
    mem_w[idx]   = nxt;
    mem_w[idx+1] = src;
    mem_w[idx+2] = fid;
    mem_w[idx+3] = (32'(pal) << 28) | 32'(len);
  endtask

  // memory responder: one burst at a time, beats in order
  initial begin
    mem_ack = 1'b0; mem_rvalid = 1'b0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_req && rst_n) begin
        rsp_a = mem_addr;
        rsp_l = int'(mem_len);
        if (req_cnt < 64) begin
          req_a[req_cnt] = rsp_a;
          req_l[req_cnt] = rsp_l;
        end
        req_cnt++;
        mem_ack = 1'b1;
        @(negedge clk);
        mem_ack = 1'b0;
        for (int i = 0; i < rsp_l; i++) begin
          mem_rvalid = 1'b1;
          mem_rdata = mem_w[8'(int'(rsp_a[9:2]) + i)];
          @(negedge clk);
          mem_rvalid = 1'b0;
          if (gap_mode && i[0]) @(negedge clk);
        end
      end
    end
  end

  // output monitor, sampled after the active edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (fifo_wr) begin fifo_log[fifo_cnt % 128] = fifo_wdata; fifo_cnt++; end
      if (pal_wr)  begin pal_log[pal_cnt % 128] = pal_wdata; pal_cnt++; end
      if (done_stb) begin done_log[done_cnt % 16] = done_fid; done_cnt++; end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    n_vec = 0; n_bad = 0;
    rst_n = 1'b0; start = 1'b0; stop_req = 1'b0; start_addr = '0; burst_sel = '0;
    underrun_en = 1'b0; fifo_free = 6'd32; pix_rd = 1'b0; fifo_empty = 1'b1;
    fifo_rdata = '0; gap_mode = 1'b0;
    for (int i = 0; i < 256; i++) mem_w[i] = '0;
    clear_logs();
    repeat (3) @(negedge clk);
    chk(!mem_req && !busy && !fifo_wr && !pal_wr && !done_stb && !underrun_flag, "R12",
        "outputs in reset", {26'd0, mem_req, busy, fifo_wr, pal_wr, done_stb, underrun_flag}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!mem_req && !busy, "R12", "idle after reset", {30'd0, mem_req, busy}, 0);

    // vector table: one self-linked descriptor each, stopped after it
    for (int v = 0; v < 7; v++) begin
      logic [1:0] sel;
      bit pal, ok_d, ok_r;
      int len, bs, nb, exp_l;
      logic [7:0] fid;
      sel = VEC[v][21:20]; pal = VEC[v][19]; gap_mode = VEC[v][18];
      len = int'(VEC[v][15:8]); fid = VEC[v][7:0];
      put_desc(0, 32'h0, 32'h200, 32'(fid), pal, len);
      for (int k = 0; k < 64; k++) mem_w[128+k] = {fid, 8'h5A, 16'(k)};
      burst_sel = sel;
      clear_logs();
      kick(32'h0, 1'b1);
      wait_idle();
      bs = (sel == 2'd0) ? 4 : (sel == 2'd1) ? 8 : 16;
      nb = (len + bs - 1) / bs;
      chk(req_a[0] == 32'h0 && req_l[0] == 4, "R1", "descriptor burst", req_a[0], 0);
      chk(done_cnt == 1 && done_log[0] == 32'(fid), "R6", "frame id strobe", done_log[0], 32'(fid));
      if (pal) chk(pal_cnt == len && fifo_cnt == 0, "R3", "palette routing", pal_cnt, len);
      else     chk(fifo_cnt == len && pal_cnt == 0, "R3", "fifo routing", fifo_cnt, len);
      ok_d = 1'b1;
      for (int k = 0; k < len; k++) begin
        if ((pal ? pal_log[k] : fifo_log[k]) != mem_w[128+k]) ok_d = 1'b0;
      end
      chk(ok_d, "R2", "data order", pal ? pal_log[0] : fifo_log[0], mem_w[128]);
      ok_r = (req_cnt == 1 + nb);
      for (int b = 0; b < nb && b < 63; b++) begin
        exp_l = (len - b * bs < bs) ? len - b * bs : bs;
        if (req_l[1+b] != exp_l || req_a[1+b] != 32'(32'h200 + 4 * b * bs)) ok_r = 1'b0;
      end
      chk(ok_r, "R4", "burst sizes", req_cnt, 1 + nb);
    end
    gap_mode = 1'b0;

    // zero-length descriptor
    put_desc(0, 32'h0, 32'h200, 32'h20, 1'b0, 0);
    clear_logs();
    kick(32'h0, 1'b1);
    wait_idle();
    chk(done_cnt == 1 && done_log[0] == 32'h20 && req_cnt == 1 && fifo_cnt == 0, "R6",
        "zero-length descriptor", req_cnt, 1);

    // FIFO space gating
    burst_sel = 2'd0;
    put_desc(0, 32'h0, 32'h200, 32'h21, 1'b0, 8);
    fifo_free = 6'd3;
    clear_logs();
    kick(32'h0, 1'b1);
    repeat (40) @(negedge clk);
    chk(req_cnt == 1 && fifo_cnt == 0 && busy, "R5", "held for space", req_cnt, 1);
    fifo_free = 6'd4;
    wait_idle();
    chk(fifo_cnt == 8 && req_cnt == 3, "R5", "resumed with space", fifo_cnt, 8);
    fifo_free = 6'd0;
    put_desc(0, 32'h0, 32'h200, 32'h22, 1'b1, 5);
    clear_logs();
    kick(32'h0, 1'b1);
    wait_idle();
    chk(pal_cnt == 5 && done_cnt == 1, "R5", "palette ignores space", pal_cnt, 5);
    fifo_free = 6'd32;

    // alternating palette/frame chain, stray start, stop after fourth
    begin
      bit ok_p, ok_f, ok_a;
      int t;
      burst_sel = 2'd1;
      put_desc(0, 32'h10, 32'h300, 32'hA1, 1'b1, 6);
      put_desc(4, 32'h0, 32'h200, 32'hB2, 1'b0, 10);
      put_desc(16, 32'h40, 32'h200, 32'hEE, 1'b0, 3);
      for (int k = 0; k < 16; k++) begin
        mem_w[192+k] = 32'hC0DE_0000 + 32'(k);
        mem_w[128+k] = 32'hF00D_0000 + 32'(k);
      end
      clear_logs();
      kick(32'h0, 1'b0);
      repeat (10) @(negedge clk);
      chk(busy, "R1", "busy during chain", {31'd0, busy}, 1);
      kick(32'h40, 1'b0);
      t = 0;
      while (done_cnt < 3 && t < 20000) begin @(negedge clk); t++; end
      stop_req = 1'b1;
      @(negedge clk);
      stop_req = 1'b0;
      wait_idle();
      chk(done_cnt == 4 && done_log[0] == 32'hA1 && done_log[1] == 32'hB2 &&
          done_log[2] == 32'hA1 && done_log[3] == 32'hB2, "R7", "alternating order",
          done_log[2], 32'hA1);
      chk(done_cnt == 4 && !busy, "R8", "stop after current", done_cnt, 4);
      ok_p = (pal_cnt == 12);
      for (int k = 0; k < 12; k++) if (pal_log[k] != 32'hC0DE_0000 + 32'(k % 6)) ok_p = 1'b0;
      chk(ok_p, "R3", "palette words in chain", pal_cnt, 12);
      ok_f = (fifo_cnt == 20);
      for (int k = 0; k < 20; k++) if (fifo_log[k] != 32'hF00D_0000 + 32'(k % 10)) ok_f = 1'b0;
      chk(ok_f, "R2", "frame words in chain", fifo_cnt, 20);
      ok_a = (req_cnt == 10);
      for (int k = 0; k < 10 && k < req_cnt; k++) if (req_a[k] == 32'h40) ok_a = 1'b0;
      chk(ok_a, "R1", "start while busy ignored", req_cnt, 10);
    end

    // underrun guard
    underrun_en = 1'b1;
    @(negedge clk);
    pix_rd = 1'b1; fifo_empty = 1'b0; fifo_rdata = 32'hCAFE_0001;
    #1 chk(fifo_rd, "R10", "pop when not empty", {31'd0, fifo_rd}, 1);
    @(negedge clk);
    chk(pix_out == 32'hCAFE_0001, "R10", "pixel loaded", pix_out, 32'hCAFE_0001);
    fifo_empty = 1'b1; fifo_rdata = 32'hDEAD_0002;
    #1 chk(!fifo_rd, "R11", "no pop when empty", {31'd0, fifo_rd}, 0);
    @(negedge clk);
    chk(pix_out == 32'hCAFE_0001 && underrun_flag, "R11", "repeat last pixel", pix_out, 32'hCAFE_0001);
    underrun_en = 1'b0;
    @(negedge clk);
    chk(pix_out == 32'h0, "R11", "zero without protection", pix_out, 0);
    pix_rd = 1'b0;
    repeat (3) @(negedge clk);
    chk(underrun_flag, "R11", "flag sticky", {31'd0, underrun_flag}, 1);
    put_desc(0, 32'h0, 32'h200, 32'h23, 1'b0, 0);
    clear_logs();
    kick(32'h0, 1'b1);
    wait_idle();
    chk(!underrun_flag, "R11", "flag cleared by start", {31'd0, underrun_flag}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule